// File: doc/BRIEF.md
# I2S to Simultaneous-Format DAC Converter

This block takes a stereo I2S stream (bit clock, word select, serial data) and re-times it for a 16-bit multibit DAC that wants a simultaneous interface: one serial line per channel, a gated bit clock and a latch-enable strobe. Each captured stereo pair is shifted out with the left and right bits in parallel on the two data lines, using exactly 16 clock pulses. The DAC clock and both data lines then stay low and quiet, so that substrate noise from the transfer can die away. Only after that quiet interval does latch enable rise, which is the moment the DAC updates its analog outputs.

The block runs entirely on a system clock that must be at least eight times the incoming bit clock. The three I2S inputs pass through two-flop synchronisers, and bit-clock edges are found by edge detection. The output bit clock is derived from the system clock, so its period does not depend on the input clock. All four outputs come straight from registers.

Inside the block, the capture stage hands each completed pair to the emitter over a valid/ready handshake. A pair stays valid and unchanged until the emitter accepts it. A pair that completes while the previous one is still pending is dropped, so back-pressure never corrupts data that is already held. This cannot happen when the clock ratio is respected, because one input frame is far longer than one output sequence.

Top module: `i2s_to_sim`

## Requirements
- R1: After reset, and until the first complete left/right pair has been captured, `dac_bck`, `dac_dl`, `dac_dr` and `dac_le` are all held low.
- R2: Word select low marks the left slot and high marks the right slot. A slot's MSB is the bit sampled on the second rising input bit clock after a word-select change. Only the first `WORD_W` bits of a slot are captured; the later bits in the slot have no effect on the output word.
- R3: Each channel word leaves the block with its MSB inverted and all other bits unchanged, which turns two's complement into offset binary.
- R4: The left and right words of one frame are shifted out in parallel and MSB first: bit k of both words is valid on `dac_dl` and `dac_dr` at the same falling edge of `dac_bck`.
- R5: Each accepted pair produces exactly `WORD_W` pulses on `dac_bck`. Each pulse is high for `HALF_CYC` system clocks and low for `HALF_CYC` system clocks. The data lines change only when `dac_bck` rises and are stable across each falling edge.
- R6: Outside the shift window, `dac_bck`, `dac_dl` and `dac_dr` are low.
- R7: `dac_le` rises exactly `HALF_CYC + QUIET_BITS*2*HALF_CYC` system clocks after the last falling edge of `dac_bck` in a window (66 with the default parameters). It stays high for `LE_BITS*2*HALF_CYC` system clocks, so it makes exactly two transitions per pair.
- R8: `dac_le` is never high while `dac_bck` is high, and it rises only while both data lines are low.
- R9: A slot is well formed only if it lasts exactly `SLOT_W` input bit clocks. If the word select changes at any other count, the partial frame is discarded and produces no latch pulse. Capture restarts at the next transition into the left slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the input bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i2s_bck | input | 1 | Incoming I2S bit clock (asynchronous) |
| i2s_ws | input | 1 | Incoming word select: 0 = left, 1 = right |
| i2s_sd | input | 1 | Incoming serial data, MSB first, delayed one bit |
| dac_bck | output | 1 | Gated output bit clock; the DAC samples on its falling edge |
| dac_dl | output | 1 | Left-channel serial data |
| dac_dr | output | 1 | Right-channel serial data |
| dac_le | output | 1 | Latch enable; the DAC updates on its rising edge |

## Verification
The stimulus is a series of well-formed frames. Each pair of patterns is chosen to expose a specific fault:
- All zeros against all ones, and 0x8000 against 0x7FFF, show whether the MSB inversion is present and sits on the right bit.
- Asymmetric words such as 0x1234/0xABCD expose swapped channels, bit reversal, and a one-bit slip in the alignment of the MSB.
- Frames carry non-zero padding after the 16th bit, so a capture window that runs too long changes the observed words.

Further frames have a left slot that is too short and a right slot that is too long. These must produce no latch pulse, and capture must recover cleanly on the following frame.

For every pair, the bench also measures:
- the width of each output clock pulse;
- the distance from the last falling edge to the rise of latch enable;
- the width of the latch pulse.

// File: rtl/i2s2sim_pkg.sv
package i2s2sim_pkg;
  typedef enum logic [1:0] {
    EM_IDLE  = 2'd0,
    EM_SHIFT = 2'd1,
    EM_QUIET = 2'd2,
    EM_LATCH = 2'd3
  } em_state_t;
endpackage

// File: rtl/bsync.sv
module bsync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= din[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl[g]  = s2;
    assign rise[g] = s2 & ~s3;
  end
endmodule

// File: rtl/i2s_capture.sv
module i2s_capture #(
  parameter int WORD_W = 16,
  parameter int SLOT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bck_rise,
  input  logic              ws,
  input  logic              sd,
  output logic              pair_valid,
  input  logic              pair_ready,
  output logic [WORD_W-1:0] pair_l,
  output logic [WORD_W-1:0] pair_r
);
  localparam int CW = $clog2(SLOT_W) + 1;
  localparam logic [CW-1:0] CMAX  = {CW{1'b1}};
  localparam logic [CW-1:0] C_END = CW'(SLOT_W - 1);
  localparam logic [CW-1:0] C_WRD = CW'(WORD_W);

  logic              ws_q, synced, left_ok;
  logic [CW-1:0]     bitcnt;
  logic [WORD_W-1:0] shl, shr;

  logic change, len_ok, take, done;
  assign change = bck_rise && (ws != ws_q);
  assign len_ok = (bitcnt == C_END);
  assign take   = bck_rise && !change && (bitcnt < C_WRD);
  assign done   = change && !ws && left_ok && len_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_q       <= 1'b1;
      synced     <= 1'b0;
      left_ok    <= 1'b0;
      bitcnt     <= CMAX;
      shl        <= '0;
      shr        <= '0;
      pair_valid <= 1'b0;
      pair_l     <= '0;
      pair_r     <= '0;
    end else begin
      if (bck_rise) ws_q <= ws;
      if (change) begin
        bitcnt <= '0;
        if (ws) begin
          left_ok <= synced && len_ok;
          if (!len_ok) synced <= 1'b0;
        end else begin
          left_ok <= 1'b0;
          synced  <= 1'b1;
        end
      end else if (bck_rise && bitcnt != CMAX) begin
        bitcnt <= bitcnt + 1'b1;
      end
      if (take) begin
        if (!ws) shl <= {shl[WORD_W-2:0], sd};
        else     shr <= {shr[WORD_W-2:0], sd};
      end
      if (done && (!pair_valid || pair_ready)) begin
        pair_valid <= 1'b1;
        pair_l     <= shl;
        pair_r     <= shr;
      end else if (pair_valid && pair_ready) begin
        pair_valid <= 1'b0;
      end
    end
  end

  // R9: a mis-sized slot leaves no half-complete frame behind
  assert_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (change && !len_ok) |=> !left_ok);

  // R2: a held pair is never altered while it waits for the emitter
  assert_pair_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !pair_ready) |=> (pair_valid && $stable(pair_l) && $stable(pair_r)));
endmodule

// File: rtl/sim_emitter.sv
module sim_emitter
  import i2s2sim_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int HALF_CYC   = 2,
  parameter int QUIET_BITS = 16,
  parameter int LE_BITS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_valid,
  output logic              pair_ready,
  input  logic [WORD_W-1:0] pair_l,
  input  logic [WORD_W-1:0] pair_r,
  output logic              o_bck,
  output logic              o_dl,
  output logic              o_dr,
  output logic              o_le
);
  localparam int BIT_CYC   = 2 * HALF_CYC;
  localparam int QUIET_CYC = QUIET_BITS * BIT_CYC;
  localparam int LE_CYC    = LE_BITS * BIT_CYC;
  localparam int TMAX      = (QUIET_CYC > LE_CYC) ? QUIET_CYC : LE_CYC;
  localparam int PW        = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int BW        = $clog2(WORD_W);
  localparam int TW        = $clog2(TMAX);
  localparam logic [PW-1:0] PH_FALL = PW'(HALF_CYC - 1);
  localparam logic [PW-1:0] PH_END  = PW'(BIT_CYC - 1);
  localparam logic [BW-1:0] B_LAST  = BW'(WORD_W - 1);
  localparam logic [TW-1:0] T_QUIET = TW'(QUIET_CYC - 1);
  localparam logic [TW-1:0] T_LE    = TW'(LE_CYC - 1);

  em_state_t         st;
  logic [PW-1:0]     ph;
  logic [BW-1:0]     bitn;
  logic [TW-1:0]     tcnt;
  logic [WORD_W-1:0] shl, shr;

  assign pair_ready = (st == EM_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= EM_IDLE; ph <= '0; bitn <= '0; tcnt <= '0;
      shl <= '0; shr <= '0;
      o_bck <= 1'b0; o_dl <= 1'b0; o_dr <= 1'b0; o_le <= 1'b0;
    end else begin
      case (st)
        EM_IDLE: if (pair_valid) begin
          shl   <= {~pair_l[WORD_W-1], pair_l[WORD_W-2:0]};
          shr   <= {~pair_r[WORD_W-1], pair_r[WORD_W-2:0]};
          o_dl  <= ~pair_l[WORD_W-1];
          o_dr  <= ~pair_r[WORD_W-1];
          o_bck <= 1'b1;
          ph    <= '0;
          bitn  <= '0;
          st    <= EM_SHIFT;
        end
        EM_SHIFT: begin
          ph <= ph + 1'b1;
          if (ph == PH_FALL) o_bck <= 1'b0;
          if (ph == PH_END) begin
            ph <= '0;
            if (bitn == B_LAST) begin
              o_dl <= 1'b0;
              o_dr <= 1'b0;
              tcnt <= '0;
              st   <= EM_QUIET;
            end else begin
              bitn  <= bitn + 1'b1;
              o_bck <= 1'b1;
              o_dl  <= shl[WORD_W-2];
              o_dr  <= shr[WORD_W-2];
              shl   <= {shl[WORD_W-2:0], 1'b0};
              shr   <= {shr[WORD_W-2:0], 1'b0};
            end
          end
        end
        EM_QUIET: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == T_QUIET) begin
            o_le <= 1'b1;
            tcnt <= '0;
            st   <= EM_LATCH;
          end
        end
        default: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == T_LE) begin
            o_le <= 1'b0;
            st   <= EM_IDLE;
          end
        end
      endcase
    end
  end

  assert_clean_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_le) |-> (!o_bck && !o_dl && !o_dr));

  assert_bck_le_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({o_bck, o_le}));

  assert_stable_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(o_bck) |-> ($stable(o_dl) && $stable(o_dr)));

  assert_accept_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_ready) |=> o_bck);
endmodule

// File: rtl/i2s_to_sim.sv
module i2s_to_sim #(
  parameter int WORD_W     = 16,
  parameter int SLOT_W     = 32,
  parameter int HALF_CYC   = 2,
  parameter int QUIET_BITS = 16,
  parameter int LE_BITS    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i2s_bck,
  input  logic i2s_ws,
  input  logic i2s_sd,
  output logic dac_bck,
  output logic dac_dl,
  output logic dac_dr,
  output logic dac_le
);
  logic [2:0]        s_lvl, s_rise;
  logic              p_valid, p_ready;
  logic [WORD_W-1:0] p_l, p_r;

  bsync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({i2s_sd, i2s_ws, i2s_bck}),
    .lvl(s_lvl), .rise(s_rise)
  );

  i2s_capture #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .bck_rise(s_rise[0]), .ws(s_lvl[1]), .sd(s_lvl[2]),
    .pair_valid(p_valid), .pair_ready(p_ready),
    .pair_l(p_l), .pair_r(p_r)
  );

  sim_emitter #(.WORD_W(WORD_W), .HALF_CYC(HALF_CYC),
                .QUIET_BITS(QUIET_BITS), .LE_BITS(LE_BITS)) u_emit (
    .clk(clk), .rst_n(rst_n),
    .pair_valid(p_valid), .pair_ready(p_ready),
    .pair_l(p_l), .pair_r(p_r),
    .o_bck(dac_bck), .o_dl(dac_dl), .o_dr(dac_dr), .o_le(dac_le)
  );
endmodule

// File: tb/sim_i2s_to_sim.sv
module sim_i2s_to_sim;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i2s_bck = 1'b0, i2s_ws = 1'b1, i2s_sd = 1'b0;
  logic dac_bck, dac_dl, dac_dr, dac_le;

  always #10 clk = ~clk;

  i2s_to_sim u0 (
    .clk(clk), .rst_n(rst_n),
    .i2s_bck(i2s_bck), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
    .dac_bck(dac_bck), .dac_dl(dac_dl), .dac_dr(dac_dr), .dac_le(dac_le)
  );

  int checks = 0, errors = 0;
  logic [31:0] expq[$];
  int n_push = 0;
  logic carry = 1'b0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic w, input logic d);
    @(negedge clk);
    i2s_bck = 1'b0; i2s_ws = w; i2s_sd = d;
    repeat (4) @(negedge clk);
    i2s_bck = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // I2S frame: data lags word select by one bit; padding bits after the word
  task automatic send_frame(input logic [15:0] l, input logic [15:0] r,
                            input int nl, input int nr, input logic [15:0] pad,
                            input bit expect_out);
    for (int i = 0; i < nl; i++) begin
      logic b;
      b = (i < 16) ? l[15-i] : pad[i%16];
      pulse(1'b0, carry); carry = b;
    end
    for (int i = 0; i < nr; i++) begin
      logic b;
      b = (i < 16) ? r[15-i] : pad[(i+5)%16];
      pulse(1'b1, carry); carry = b;
    end
    if (expect_out) begin
      expq.push_back({~l[15], l[14:0], ~r[15], r[14:0]});
      n_push++;
    end
  endtask

  // scoreboard monitor
  logic pb = 0, ple = 0, pdl = 0, pdr = 0;
  int hi_cnt = 0, since_fall = 0, le_hi = 0, nbits = 0, le_rises = 0, falls = 0;
  logic [15:0] wl = 0, wr = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (dac_bck) hi_cnt = pb ? hi_cnt + 1 : 1;
      if (pb && !dac_bck) begin
        chk(hi_cnt == 2, "R5 high width", hi_cnt, 2);
        chk(dac_dl == pdl && dac_dr == pdr, "R5 data stable at fall",
            {dac_dl, dac_dr}, {pdl, pdr});
        wl = {wl[14:0], dac_dl};
        wr = {wr[14:0], dac_dr};
        nbits++; falls++;
        since_fall = 0;
      end else begin
        since_fall++;
      end
      if (dac_le && !ple) begin
        le_rises++;
        chk(nbits == 16, "R5 pulse count", nbits, 16);
        chk(since_fall == 66, "R7 quiet gap", since_fall, 66);
        chk(!dac_bck && !dac_dl && !dac_dr, "R6/R8 idle at latch",
            {dac_bck, dac_dl, dac_dr}, 0);
        if (expq.size() == 0) begin
          chk(0, "R9 unexpected latch", {wl, wr}, 0);
        end else begin
          logic [31:0] e;
          e = expq.pop_front();
          chk({wl, wr} == e, "R2/R3/R4 pair words", {wl, wr}, e);
        end
        nbits = 0;
        le_hi = 1;
      end else if (dac_le) begin
        le_hi++;
      end
      if (!dac_le && ple) chk(le_hi == 32, "R7 latch width", le_hi, 32);
      if (!dac_bck && nbits == 0 && !dac_le)
        if (dac_dl || dac_dr) chk(0, "R6 data outside window", {dac_dl, dac_dr}, 0);
      pb = dac_bck; ple = dac_le; pdl = dac_dl; pdr = dac_dr;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk({dac_bck, dac_dl, dac_dr, dac_le} == 4'b0, "R1 reset idle",
        {dac_bck, dac_dl, dac_dr, dac_le}, 0);
    send_frame(16'h0000, 16'hFFFF, 32, 32, 16'hFFFF, 1);
    repeat (20) @(negedge clk);
    chk(le_rises == 0 && falls == 0, "R1 idle before first pair", le_rises + falls, 0);
    send_frame(16'h8000, 16'h7FFF, 32, 32, 16'hC3C3, 1);
    send_frame(16'h1234, 16'hABCD, 32, 32, 16'hFFFF, 1);
    send_frame(16'hA5A5, 16'h5A5A, 32, 32, 16'h0F0F, 1);
    // R9: short left slot -> discarded
    send_frame(16'hDEAD, 16'hBEEF, 20, 32, 16'h1111, 0);
    send_frame(16'h0F0F, 16'hF0F0, 32, 32, 16'hFFFF, 1);
    // R9: long right slot -> discarded
    send_frame(16'h7777, 16'h3333, 32, 40, 16'hAAAA, 0);
    send_frame(16'hFFFF, 16'h0001, 32, 32, 16'h5555, 1);
    send_frame(16'h0000, 16'h0000, 32, 32, 16'h0000, 0); // completes previous
    repeat (400) @(negedge clk);
    chk(expq.size() == 0, "R9 all good pairs emitted", expq.size(), 0);
    chk(le_rises == n_push, "R9 latch count", le_rises, n_push);
    chk(falls == 16 * n_push, "R5 total pulses", falls, 16 * n_push);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule